// File: doc/BRIEF.md
# Gated Multi-Output Clock Fanout

This block takes one of two clock sources, a fast system clock or a slower scan/test clock, and drives the chosen clock onto six output pairs. Each pair has a true output and a complement output. A single select line chooses the source. Logic low chooses the system clock, so that level is the normal operating setting.

Every output has a gate. The gate is controlled by one enable shared by all outputs and by an enable of its own. Both enables are active-low. The gating state is captured by a flip-flop clocked on the falling edge of the selected clock. An output is therefore only stopped or restarted while it is already low, and every high pulse on an output is a full high phase of the source clock. An active-low reset clears every gate at once.

The output count and the enable polarity are parameters. The default is six outputs with active-low enables.

Top module: `gated_clock_fanout`

## Requirements
- R1: With `src_sel` = 0, each running true output follows `sys_clk` (high in the high phase of `sys_clk`, low in its low phase), and `scan_clk` has no effect on any output.
- R2: With `src_sel` = 1, each running true output follows `scan_clk`, and `sys_clk` has no effect on any output.
- R3: Output i runs only when `com_en_n` = 0 and `out_en_n[i]` = 0. Bit i of `out_en_n` controls pair i. A stopped true output is held at 0.
- R4: The enables are sampled only on the falling edge of the selected clock. A change made during a low phase leaves the following high phase unchanged and takes effect from the next falling edge. A true output rises only with a rising edge of the selected clock and falls only with a falling edge, so every high pulse lasts one full high phase.
- R5: `clk_out_b[i]` is always the inverse of `clk_out[i]`.
- R6: While `rst_n` = 0 all true outputs are 0. This holds at once, even in a high phase. After `rst_n` returns to 1, the outputs stay 0 until a falling edge of the selected clock has sampled the enables.
- R7: Changing the individual enable of one output leaves every other output unchanged.
- R8: `com_en_n` = 1, once sampled, stops all outputs regardless of `out_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | High-speed system clock source |
| scan_clk | input | 1 | Slow scan/test clock source |
| src_sel | input | 1 | Source select: 0 = system clock, 1 = scan clock |
| rst_n | input | 1 | Asynchronous active-low reset of all gates |
| com_en_n | input | 1 | Shared enable, active-low |
| out_en_n | input | 6 | Per-output enables, active-low, bit i for pair i |
| clk_out | output | 6 | True clock outputs |
| clk_out_b | output | 6 | Complement clock outputs |

## Verification
On every clock, the assertions check three things. First, the high phase seen at each falling edge matches the enables captured at the falling edge before it. Second, all true outputs are low in each low phase and under reset. Third, a shared disable that has been sampled silences every output.

Some behaviour can only be shown by the directed scenarios and the bench's pulse monitor:
- that each source is really chosen by the select line while the other clock is ignored;
- the exact one-phase latency of an enable change;
- that outputs stay independent of one another;
- the complement pins;
- that no high pulse is shorter than a full source high phase.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

   // Clock source encoding of the select line
   typedef enum logic {
      SRC_SYS  = 1'b0,
      SRC_SCAN = 1'b1
   } src_sel_e;

   localparam int unsigned GCF_MAX_OUTPUTS = 32;

endpackage

// File: rtl/gcf_src_select.sv
module gcf_src_select
   import gcf_pkg::*;
(
   input  logic sys_clk,
   input  logic scan_clk,
   input  logic src_sel,
   output logic clk_mux
);

   src_sel_e sel_e;

   assign sel_e   = src_sel_e'(src_sel);
   assign clk_mux = (sel_e == SRC_SCAN) ? scan_clk : sys_clk;

endmodule

// File: rtl/gcf_enable_decode.sv
module gcf_enable_decode #(
   parameter int unsigned NUM_OUT       = 6,
   parameter bit          EN_ACTIVE_LOW = 1'b1
) (
   input  logic               com_en,
   input  logic [NUM_OUT-1:0] out_en,
   output logic [NUM_OUT-1:0] want_run
);

   logic [NUM_OUT-1:0] com_vec;

   assign com_vec = {NUM_OUT{com_en}};

   generate
      if (EN_ACTIVE_LOW) begin : g_low
         assign want_run = ~(com_vec | out_en);
      end else begin : g_high
         assign want_run = com_vec & out_en;
      end
   endgenerate

endmodule

// File: rtl/gcf_gate_cell.sv
module gcf_gate_cell (
   input  logic clk_src,
   input  logic rst_n,
   input  logic want_run,
   output logic clk_q,
   output logic clk_qb
);

   logic run_q;

   // Gate state changes on the falling edge only, while clk_src is low
   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else begin
         run_q <= want_run;
      end
   end

   assign clk_q  = clk_src & run_q;
   assign clk_qb = ~clk_q;

endmodule

// File: rtl/gated_clock_fanout.sv
module gated_clock_fanout
   import gcf_pkg::*;
#(
   parameter int unsigned NUM_OUT       = 6,
   parameter bit          EN_ACTIVE_LOW = 1'b1
) (
   input  logic               sys_clk,
   input  logic               scan_clk,
   input  logic               src_sel,
   input  logic               rst_n,
   input  logic               com_en_n,
   input  logic [NUM_OUT-1:0] out_en_n,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [NUM_OUT-1:0] clk_out_b
);

   generate
      if (NUM_OUT < 1 || NUM_OUT > GCF_MAX_OUTPUTS) begin : g_bad_count
         $error("gated_clock_fanout: NUM_OUT out of range");
      end
   endgenerate

   logic               clk_mux;
   logic [NUM_OUT-1:0] want_run;

   gcf_src_select u_src_select (
      .sys_clk  (sys_clk),
      .scan_clk (scan_clk),
      .src_sel  (src_sel),
      .clk_mux  (clk_mux)
   );

   gcf_enable_decode #(
      .NUM_OUT       (NUM_OUT),
      .EN_ACTIVE_LOW (EN_ACTIVE_LOW)
   ) u_enable_decode (
      .com_en   (com_en_n),
      .out_en   (out_en_n),
      .want_run (want_run)
   );

   generate
      for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
         gcf_gate_cell u_gate (
            .clk_src  (clk_mux),
            .rst_n    (rst_n),
            .want_run (want_run[gi]),
            .clk_q    (clk_out[gi]),
            .clk_qb   (clk_out_b[gi])
         );
      end
   endgenerate

endmodule

// File: rtl/gcf_checker.sv
module gcf_checker #(
   parameter int unsigned NUM_OUT       = 6,
   parameter bit          EN_ACTIVE_LOW = 1'b1
) (
   input logic               clk_mux,
   input logic               rst_n,
   input logic               com_en,
   input logic [NUM_OUT-1:0] out_en,
   input logic [NUM_OUT-1:0] clk_out
);

   logic [NUM_OUT-1:0] act_vec;
   logic               com_off;
   logic [1:0]         fall_cnt;

   assign act_vec = EN_ACTIVE_LOW ? ~({NUM_OUT{com_en}} | out_en)
                                  :  ({NUM_OUT{com_en}} & out_en);
   assign com_off = EN_ACTIVE_LOW ? com_en : ~com_en;

   // Falling edges seen since reset release, saturating
   always_ff @(negedge clk_mux or negedge rst_n) begin
      if (!rst_n) begin
         fall_cnt <= 2'd0;
      end else if (fall_cnt != 2'd3) begin
         fall_cnt <= fall_cnt + 2'd1;
      end
   end

   // The high phase before each falling edge shows the enables captured one falling edge earlier
   p_gate_follows_r3: assert property (@(negedge clk_mux) disable iff (!rst_n)
      (fall_cnt != 2'd0) |-> (clk_out == $past(act_vec)));

   // Every low phase is quiet on all true outputs
   p_low_phase_quiet_r4: assert property (@(posedge clk_mux) disable iff (!rst_n)
      clk_out == '0);

   // Reset holds all true outputs low
   p_reset_low_r6: assert property (@(posedge clk_mux)
      (rst_n == 1'b0) |-> (clk_out == '0));

   // A sampled shared disable silences every output
   p_common_stop_r8: assert property (@(negedge clk_mux) disable iff (!rst_n)
      ((fall_cnt != 2'd0) && $past(com_off)) |-> (clk_out == '0));

endmodule

bind gated_clock_fanout gcf_checker #(
   .NUM_OUT       (NUM_OUT),
   .EN_ACTIVE_LOW (EN_ACTIVE_LOW)
) u_gcf_checker (
   .clk_mux (clk_mux),
   .rst_n   (rst_n),
   .com_en  (com_en_n),
   .out_en  (out_en_n),
   .clk_out (clk_out)
);

// File: tb/test_gated_clock_fanout.sv
`timescale 1ns/10ps
module test_gated_clock_fanout;

   localparam int N = 6;

   logic         sys_clk  = 1'b0;
   logic         scan_clk = 1'b0;
   logic         src_sel  = 1'b0;
   logic         rst_n    = 1'b0;
   logic         com_en_n = 1'b1;
   logic [N-1:0] out_en_n = '1;
   logic [N-1:0] clk_out;
   logic [N-1:0] clk_out_b;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   // Bench view of the source chosen by the select line (R1, R2)
   wire selclk_b = src_sel ? scan_clk : sys_clk;

   gated_clock_fanout #(.NUM_OUT(N)) i_gated_clock_fanout (
      .sys_clk   (sys_clk),
      .scan_clk  (scan_clk),
      .src_sel   (src_sel),
      .rst_n     (rst_n),
      .com_en_n  (com_en_n),
      .out_en_n  (out_en_n),
      .clk_out   (clk_out),
      .clk_out_b (clk_out_b)
   );

   // 200 MHz system clock, 25 MHz scan clock
   initial forever #2.5 sys_clk = ~sys_clk;
   initial forever #20.0 scan_clk = ~scan_clk;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic at_high();
      @(posedge selclk_b);
      #(src_sel ? 10.0 : 1.25);
   endtask

   task automatic at_low();
      @(negedge selclk_b);
      #(src_sel ? 10.0 : 1.25);
   endtask

   // Pulse monitor: edges tied to source edges, no pulse shorter than a high phase (R4)
   logic [N-1:0] prev_out = '0;
   realtime      rise_t [N];
   always @(clk_out) begin
      for (int i = 0; i < N; i++) begin
         if (clk_out[i] !== prev_out[i]) begin
            if (clk_out[i] === 1'b1) begin
               rise_t[i] = $realtime;
               chk("R4 rise on source rise", {{(N-1){1'b0}}, selclk_b}, {{(N-1){1'b0}}, 1'b1});
            end else if (rst_n === 1'b1) begin
               chk("R4 fall on source fall", {{(N-1){1'b0}}, selclk_b}, {{(N-1){1'b0}}, 1'b0});
               n_checks++;
               if (($realtime - rise_t[i]) < ((src_sel ? 20.0 : 2.5) - 0.05)) begin
                  n_fails++;
                  $display("FAIL R4 runt pulse on output %0d: actual width %0t expected full phase",
                           i, $realtime - rise_t[i]);
               end
            end
         end
      end
      prev_out = clk_out;
   end

   task automatic test_reset();
      at_high();
      chk("R6 outputs low in reset", clk_out, 6'h00);
      chk("R5 complement in reset", clk_out_b, 6'h3F);
      com_en_n = 1'b0;
      out_en_n = '0;
      at_high();
      at_high();
      chk("R6 reset overrides enables", clk_out, 6'h00);
      rst_n = 1'b1;
      #0.2;
      chk("R6 low until first falling edge", clk_out, 6'h00);
      at_high();
      chk("R6 running after first sample", clk_out, 6'h3F);
      chk("R5 complement running high", clk_out_b, 6'h00);
   endtask

   task automatic test_sys_select();
      for (int k = 0; k < 10; k++) begin
         at_high();
         chk("R1 high phase of sys_clk", clk_out, 6'h3F);
         at_low();
         chk("R1 low phase of sys_clk", clk_out, 6'h00);
         chk("R5 complement low phase", clk_out_b, 6'h3F);
      end
   endtask

   task automatic test_latency();
      at_low();
      out_en_n[2] = 1'b1;
      at_high();
      chk("R4 disable not yet taken", clk_out, 6'h3F);
      at_high();
      chk("R4 disable after falling edge", clk_out, 6'h3B);
      at_low();
      out_en_n[2] = 1'b0;
      at_high();
      chk("R4 enable not yet taken", clk_out, 6'h3B);
      at_high();
      chk("R4 enable after falling edge", clk_out, 6'h3F);
   endtask

   task automatic test_individual();
      at_low();
      out_en_n = 6'b010101;
      at_high();
      at_high();
      chk("R3 pattern 010101", clk_out, 6'b101010);
      at_low();
      out_en_n = 6'b110011;
      at_high();
      at_high();
      chk("R3 pattern 110011", clk_out, 6'b001100);
      at_low();
      out_en_n = 6'b110010;
      at_high();
      at_high();
      chk("R7 only output 0 changes", clk_out, 6'b001101);
      at_low();
      chk("R3 low phase quiet", clk_out, 6'h00);
      out_en_n = '0;
      at_high();
      at_high();
   endtask

   task automatic test_common();
      at_low();
      com_en_n = 1'b1;
      at_high();
      chk("R8 shared disable not yet taken", clk_out, 6'h3F);
      at_high();
      chk("R8 shared disable stops all", clk_out, 6'h00);
      at_low();
      out_en_n = 6'b101010;
      at_high();
      at_high();
      chk("R8 individual enables ignored", clk_out, 6'h00);
      at_low();
      com_en_n = 1'b0;
      at_high();
      chk("R8 restart not yet taken", clk_out, 6'h00);
      at_high();
      chk("R8 restart with pattern", clk_out, 6'b010101);
      at_low();
      out_en_n = '0;
      at_high();
      at_high();
   endtask

   task automatic test_scan_select();
      at_low();
      com_en_n = 1'b1;
      at_high();
      at_high();
      at_low();
      src_sel = 1'b1;
      at_low();
      at_low();
      com_en_n = 1'b0;
      at_high();
      chk("R2 scan restart not yet taken", clk_out, 6'h00);
      at_high();
      chk("R2 high phase of scan_clk", clk_out, 6'h3F);
      #7.0;
      chk("R2 sys_clk ignored in scan high", clk_out, 6'h3F);
      at_low();
      chk("R2 low phase of scan_clk", clk_out, 6'h00);
      #7.0;
      chk("R2 sys_clk ignored in scan low", clk_out, 6'h00);
      com_en_n = 1'b1;
      at_high();
      at_high();
      chk("R8 shared disable on scan", clk_out, 6'h00);
      at_low();
      src_sel = 1'b0;
      at_low();
      at_low();
      com_en_n = 1'b0;
      at_high();
      at_high();
      chk("R1 back on sys_clk", clk_out, 6'h3F);
   endtask

   task automatic test_async_reset();
      at_high();
      rst_n = 1'b0;
      #0.2;
      chk("R6 reset cuts high phase", clk_out, 6'h00);
      chk("R5 complement on reset", clk_out_b, 6'h3F);
      at_high();
      chk("R6 held in reset", clk_out, 6'h00);
      at_low();
      rst_n = 1'b1;
      at_high();
      chk("R6 low before first sample", clk_out, 6'h00);
      at_high();
      chk("R6 running after release", clk_out, 6'h3F);
   endtask

   initial begin
      test_reset();
      test_sys_select();
      test_latency();
      test_individual();
      test_common();
      test_scan_select();
      test_async_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #200us;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule